// File: doc/BRIEF.md
# Instruction Fetch Stage for a Two-Stage Pipeline

This block is the front half of a two-stage processor pipeline. It owns the program counter and keeps an instruction-read request pending on the memory side at all times. It places each returned instruction word, together with the address it came from, into a single pipeline register. That register carries a flush flag, which tells the execute stage whether the entry may be used.

The program counter stores only the word-address bits, so no misaligned fetch can be formed. A taken branch reloads the counter from the branch target and marks the pipeline entry as dead. A sequential read that was already in flight when the branch was taken still completes on the bus, and the block discards its data.

A low PC write enable is a stall. During a stall the counter and the pipeline register keep their values, so the held instruction survives and does not have to be fetched again.

A controller with three states drives the datapath:
- **BOOT** is held during reset and for the first cycle after it. No read is requested in this state.
- **FETCH** is the normal state. A request is outstanding and its response is used.
- **DRAIN** is entered when a branch is taken while the old request has not yet answered. The next response, valid or error, is thrown away.

The transitions are:
- BOOT→FETCH on the first edge without reset.
- FETCH→DRAIN when a branch is taken with no response in that cycle.
- DRAIN→FETCH on any response.
- FETCH→FETCH and DRAIN→DRAIN otherwise, with DRAIN re-entered if another branch arrives before the response.

Top module: `fetch_unit`

## Requirements
- R1: While reset is high, `fetch_addr` equals `BOOT_ADDR` with bits 1:0 cleared, `flush_out` is 1 and `ird_en` is 0.
- R2: From the second rising edge after reset is released, `ird_en` is 1 in every cycle.
- R3: `fetch_addr` and `instr_pc` always have bits 1:0 equal to 0. `fetch_addr` is the stored counter followed by two zero bits.
- R4: In FETCH, with `pc_we`=1, `br_taken`=0, `ird_err`=0 and `ird_valid`=1, the next edge loads `ird_data` into `instr_out` and the current `fetch_addr` into `instr_pc`. The same edge clears `flush_out` and advances `fetch_addr` by 4, wrapping from all-ones to zero.
- R5: `br_taken`=1 has priority over stall, error and data. After the edge, `fetch_addr` equals `br_target` with bits 1:0 cleared and `flush_out` is 1. Any response in that cycle is discarded.
- R6: A branch taken without a response in the same cycle makes the next response (valid or error) be discarded. That response leaves `instr_out`, `instr_pc`, `flush_out` and `fetch_addr` unchanged. The response after it is used normally.
- R7: With `pc_we`=0 and `br_taken`=0, `fetch_addr`, `instr_out`, `instr_pc` and `flush_out` keep their values, and any response in that cycle is dropped.
- R8: In FETCH, with `pc_we`=1 and `br_taken`=0, `ird_err`=1 (whatever `ird_valid` is) sets `flush_out` to 1 and leaves `fetch_addr` unchanged, so the same word is requested again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| br_taken | input | 1 | Branch or jump taken this cycle |
| br_target | input | XLEN | Redirect address; bits 1:0 ignored |
| pc_we | input | 1 | PC write enable; low stalls the stage |
| ird_err | input | 1 | Instruction read ended with a bus error |
| ird_valid | input | 1 | Instruction read data is valid this cycle |
| ird_data | input | ILEN | Returned instruction word |
| fetch_addr | output | XLEN | Word-aligned address of the pending read |
| ird_en | output | 1 | Instruction read request |
| instr_out | output | ILEN | Instruction held in the pipeline register |
| instr_pc | output | XLEN | Address of the held instruction |
| flush_out | output | 1 | Pipeline register entry is invalid |

## Verification
The bench builds the block with XLEN=32, ILEN=32 and a boot address of 0x100. The non-zero boot address shows that the reset value comes from the parameter and not from zero. The full 32-bit width lets a branch to 0xFFFFFFFC followed by one accepted word exercise the counter wrap to address zero. An unaligned branch target (0x303) shows that the low bits are dropped. A branch taken during a stall, and a second branch taken while a discard is still pending, show that the DRAIN state and the hold paths agree with the priority order.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    // Controller states
    typedef enum logic [1:0] {
        FS_BOOT  = 2'd0,
        FS_FETCH = 2'd1,
        FS_DRAIN = 2'd2
    } fetch_state_e;

    // Program counter operation
    typedef enum logic [1:0] {
        PC_HOLD = 2'd0,
        PC_STEP = 2'd1,
        PC_LOAD = 2'd2
    } pc_op_e;

    // Pipeline register operation
    typedef enum logic [1:0] {
        PIPE_KEEP = 2'd0,
        PIPE_FILL = 2'd1,
        PIPE_KILL = 2'd2
    } pipe_op_e;

endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
    import fetch_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         br_taken,
    input  logic         pc_we,
    input  logic         ird_err,
    input  logic         ird_valid,
    output fetch_state_e state_o,
    output pc_op_e       pc_op_o,
    output pipe_op_e     pipe_op_o,
    output logic         req_en_o
);

    fetch_state_e state_q;
    fetch_state_e state_d;
    logic         resp;

    assign resp = ird_valid | ird_err;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_BOOT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and datapath commands
    // Priority: branch > stall > error > data
    always_comb begin
        state_d   = state_q;
        pc_op_o   = PC_HOLD;
        pipe_op_o = PIPE_KEEP;
        unique case (state_q)
            FS_BOOT: begin
                // no request outstanding yet
                state_d = FS_FETCH;
                if (br_taken) begin
                    pc_op_o   = PC_LOAD;
                    pipe_op_o = PIPE_KILL;
                end
            end
            FS_FETCH: begin
                if (br_taken) begin
                    pc_op_o   = PC_LOAD;
                    pipe_op_o = PIPE_KILL;
                    state_d   = resp ? FS_FETCH : FS_DRAIN;
                end else if (!pc_we) begin
                    state_d = FS_FETCH;
                end else if (ird_err) begin
                    pipe_op_o = PIPE_KILL;
                    state_d   = FS_FETCH;
                end else if (ird_valid) begin
                    pc_op_o   = PC_STEP;
                    pipe_op_o = PIPE_FILL;
                    state_d   = FS_FETCH;
                end else begin
                    state_d = FS_FETCH;
                end
            end
            FS_DRAIN: begin
                // the stale response is discarded
                if (br_taken) begin
                    pc_op_o   = PC_LOAD;
                    pipe_op_o = PIPE_KILL;
                end
                state_d = resp ? FS_FETCH : FS_DRAIN;
            end
            default: begin
                state_d = FS_BOOT;
            end
        endcase
    end

    assign state_o  = state_q;
    assign req_en_o = (state_q != FS_BOOT);

endmodule

// File: rtl/fetch_pc_reg.sv
module fetch_pc_reg
    import fetch_pkg::*;
#(
    parameter int                XLEN      = 32,
    parameter logic [XLEN-1:0]   BOOT_ADDR = '0,
    localparam int               PCW       = XLEN - 2
) (
    input  logic           clk,
    input  logic           rst,
    input  pc_op_e         op,
    input  logic [PCW-1:0] target_word,
    output logic [PCW-1:0] pc_word
);

    logic [PCW-1:0] pc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= BOOT_ADDR[XLEN-1:2];
        end else begin
            case (op)
                PC_STEP: pc_q <= pc_q + PCW'(1);
                PC_LOAD: pc_q <= target_word;
                default: pc_q <= pc_q;
            endcase
        end
    end

    assign pc_word = pc_q;

endmodule

// File: rtl/fetch_pipe_reg.sv
module fetch_pipe_reg
    import fetch_pkg::*;
#(
    parameter int  XLEN = 32,
    parameter int  ILEN = 32,
    localparam int PCW  = XLEN - 2
) (
    input  logic            clk,
    input  logic            rst,
    input  pipe_op_e        op,
    input  logic [ILEN-1:0] word_i,
    input  logic [PCW-1:0]  pc_word_i,
    output logic [ILEN-1:0] instr_o,
    output logic [XLEN-1:0] pc_o,
    output logic            flush_o
);

    logic [ILEN-1:0] instr_q;
    logic [PCW-1:0]  pcw_q;
    logic            flush_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            instr_q <= '0;
            pcw_q   <= '0;
            flush_q <= 1'b1;
        end else begin
            case (op)
                PIPE_FILL: begin
                    instr_q <= word_i;
                    pcw_q   <= pc_word_i;
                    flush_q <= 1'b0;
                end
                PIPE_KILL: begin
                    flush_q <= 1'b1;
                end
                default: begin
                    flush_q <= flush_q;
                end
            endcase
        end
    end

    assign instr_o = instr_q;
    assign pc_o    = {pcw_q, 2'b00};
    assign flush_o = flush_q;

endmodule

// File: rtl/fetch_unit.sv
module fetch_unit
    import fetch_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              ILEN      = 32,
    parameter logic [XLEN-1:0] BOOT_ADDR = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            br_taken,
    input  logic [XLEN-1:0] br_target,
    input  logic            pc_we,
    input  logic            ird_err,
    input  logic            ird_valid,
    input  logic [ILEN-1:0] ird_data,
    output logic [XLEN-1:0] fetch_addr,
    output logic            ird_en,
    output logic [ILEN-1:0] instr_out,
    output logic [XLEN-1:0] instr_pc,
    output logic            flush_out
);

    localparam int PCW = XLEN - 2;

    fetch_state_e   ctrl_state;
    pc_op_e         pc_op;
    pipe_op_e       pipe_op;
    logic [PCW-1:0] pc_word;
    logic           unused_tgt_bits;

    assign unused_tgt_bits = ^br_target[1:0];

    fetch_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .br_taken  (br_taken),
        .pc_we     (pc_we),
        .ird_err   (ird_err),
        .ird_valid (ird_valid),
        .state_o   (ctrl_state),
        .pc_op_o   (pc_op),
        .pipe_op_o (pipe_op),
        .req_en_o  (ird_en)
    );

    fetch_pc_reg #(
        .XLEN      (XLEN),
        .BOOT_ADDR (BOOT_ADDR)
    ) u_pc (
        .clk         (clk),
        .rst         (rst),
        .op          (pc_op),
        .target_word (br_target[XLEN-1:2]),
        .pc_word     (pc_word)
    );

    fetch_pipe_reg #(
        .XLEN (XLEN),
        .ILEN (ILEN)
    ) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .op        (pipe_op),
        .word_i    (ird_data),
        .pc_word_i (pc_word),
        .instr_o   (instr_out),
        .pc_o      (instr_pc),
        .flush_o   (flush_out)
    );

    assign fetch_addr = {pc_word, 2'b00};

endmodule

// File: rtl/fetch_unit_chk.sv
module fetch_unit_chk
    import fetch_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int ILEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            br_taken,
    input logic [XLEN-1:0] br_target,
    input logic            pc_we,
    input logic            ird_err,
    input logic            ird_valid,
    input logic [XLEN-1:0] fetch_addr,
    input logic            ird_en,
    input logic [ILEN-1:0] instr_out,
    input logic [XLEN-1:0] instr_pc,
    input logic            flush_out,
    input fetch_state_e    ctrl_state
);

    // R2
    a_r2_req_pending: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ird_en);

    // R3
    a_r3_aligned: assert property (@(posedge clk) disable iff (rst)
        (fetch_addr[1:0] == 2'b00) && (instr_pc[1:0] == 2'b00));

    // R4
    a_r4_fill: assert property (@(posedge clk) disable iff (rst)
        (ctrl_state == FS_FETCH && pc_we && !br_taken && !ird_err && ird_valid)
        |=> (instr_pc == $past(fetch_addr)) && !flush_out
            && (fetch_addr == $past(fetch_addr) + XLEN'(4)));

    // R5
    a_r5_redirect: assert property (@(posedge clk) disable iff (rst)
        br_taken |=> (fetch_addr == {$past(br_target[XLEN-1:2]), 2'b00}) && flush_out);

    // R6
    a_r6_drain_discard: assert property (@(posedge clk) disable iff (rst)
        (ctrl_state == FS_DRAIN && !br_taken)
        |=> $stable(instr_pc) && $stable(instr_out) && $stable(fetch_addr) && $stable(flush_out));

    // R7
    a_r7_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (!pc_we && !br_taken)
        |=> $stable(instr_pc) && $stable(instr_out) && $stable(fetch_addr) && $stable(flush_out));

    // R8
    a_r8_err_kill: assert property (@(posedge clk) disable iff (rst)
        (ctrl_state == FS_FETCH && pc_we && !br_taken && ird_err)
        |=> flush_out && $stable(fetch_addr));

endmodule

bind fetch_unit fetch_unit_chk #(
    .XLEN (XLEN),
    .ILEN (ILEN)
) u_fetch_chk (
    .clk        (clk),
    .rst        (rst),
    .br_taken   (br_taken),
    .br_target  (br_target),
    .pc_we      (pc_we),
    .ird_err    (ird_err),
    .ird_valid  (ird_valid),
    .fetch_addr (fetch_addr),
    .ird_en     (ird_en),
    .instr_out  (instr_out),
    .instr_pc   (instr_pc),
    .flush_out  (flush_out),
    .ctrl_state (ctrl_state)
);

// File: tb/tb_fetch_unit.sv
`timescale 1ns/1ps
module tb_fetch_unit;

    localparam int              XLEN = 32;
    localparam int              ILEN = 32;
    localparam logic [XLEN-1:0] BOOT = 32'h0000_0100;

    logic            clk = 1'b0;
    logic            rst;
    logic            br_taken;
    logic [XLEN-1:0] br_target;
    logic            pc_we;
    logic            ird_err;
    logic            ird_valid;
    logic [ILEN-1:0] ird_data;
    logic [XLEN-1:0] fetch_addr;
    logic            ird_en;
    logic [ILEN-1:0] instr_out;
    logic [XLEN-1:0] instr_pc;
    logic            flush_out;

    always #10 clk = ~clk;

    fetch_unit #(
        .XLEN      (XLEN),
        .ILEN      (ILEN),
        .BOOT_ADDR (BOOT)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .br_taken   (br_taken),
        .br_target  (br_target),
        .pc_we      (pc_we),
        .ird_err    (ird_err),
        .ird_valid  (ird_valid),
        .ird_data   (ird_data),
        .fetch_addr (fetch_addr),
        .ird_en     (ird_en),
        .instr_out  (instr_out),
        .instr_pc   (instr_pc),
        .flush_out  (flush_out)
    );

    int checks = 0;
    int errors = 0;

    // scoreboard: {pc, instruction}
    logic [63:0]     exp_q[$];

    // reference state derived from the requirements
    logic [XLEN-3:0] rpc;
    logic            rflush;
    logic            rdrain;
    string           pend;

    logic            mon_on = 1'b0;
    logic [XLEN-1:0] prev_pc = '0;
    logic            prev_flush = 1'b1;

    function automatic logic [ILEN-1:0] word_at(input logic [XLEN-1:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic look(input string req);
        chk(fetch_addr == {rpc, 2'b00}, req, "fetch_addr", 64'(fetch_addr), 64'({rpc, 2'b00}));
        chk(flush_out == rflush, req, "flush_out", 64'(flush_out), 64'(rflush));
        chk(ird_en == 1'b1, "R2", "ird_en", 64'(ird_en), 64'd1);
    endtask

    task automatic step(input logic tk, input logic [XLEN-1:0] tgt, input logic we,
                        input logic er, input logic vl, input string req);
        logic            resp;
        logic [ILEN-1:0] w;
        @(negedge clk);
        look(pend);
        w         = word_at(fetch_addr);
        br_taken  = tk;
        br_target = tgt;
        pc_we     = we;
        ird_err   = er;
        ird_valid = vl;
        ird_data  = w;
        resp      = er | vl;
        if (tk) begin
            rpc    = tgt[XLEN-1:2];
            rflush = 1'b1;
            rdrain = !resp;
        end else if (rdrain) begin
            if (resp) rdrain = 1'b0;
        end else if (!we) begin
            rdrain = 1'b0;
        end else if (er) begin
            rflush = 1'b1;
        end else if (vl) begin
            exp_q.push_back({{rpc, 2'b00}, w});
            rpc    = rpc + 1'b1;
            rflush = 1'b0;
        end
        pend = req;
    endtask

    // Monitor: a new pipeline entry pops the scoreboard
    always @(negedge clk) begin
        if (mon_on) begin
            if (!flush_out && (instr_pc != prev_pc || prev_flush)) begin
                chk(instr_pc[1:0] == 2'b00, "R3", "instr_pc align", 64'(instr_pc), 64'd0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4", "unexpected entry", {instr_pc, instr_out}, 64'd0);
                end else begin
                    logic [63:0] e;
                    e = exp_q.pop_front();
                    chk({instr_pc, instr_out} == e, "R4", "pipeline entry",
                        {instr_pc, instr_out}, e);
                end
            end
            prev_pc    = instr_pc;
            prev_flush = flush_out;
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst       = 1'b1;
        br_taken  = 1'b0;
        br_target = '0;
        pc_we     = 1'b1;
        ird_err   = 1'b0;
        ird_valid = 1'b0;
        ird_data  = '0;
        rpc       = BOOT[XLEN-1:2];
        rflush    = 1'b1;
        rdrain    = 1'b0;

        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            chk(fetch_addr == BOOT, "R1", "fetch_addr", 64'(fetch_addr), 64'(BOOT));
            chk(flush_out == 1'b1, "R1", "flush_out", 64'(flush_out), 64'd1);
            chk(ird_en == 1'b0, "R1", "ird_en", 64'(ird_en), 64'd0);
        end
        @(negedge clk);
        rst    = 1'b0;
        mon_on = 1'b1;
        pend   = "R2";

        // R4: sequential fetches with varying latency
        step(0, '0, 1, 0, 0, "R4");
        step(0, '0, 1, 0, 1, "R4");
        step(0, '0, 1, 0, 1, "R4");
        step(0, '0, 1, 0, 0, "R4");
        step(0, '0, 1, 0, 1, "R4");
        // R7: stall holds everything and drops the response
        step(0, '0, 0, 0, 1, "R7");
        step(0, '0, 0, 0, 0, "R7");
        step(0, '0, 1, 0, 1, "R7");
        // R8: bus error flushes and refetches the same word
        step(0, '0, 1, 1, 0, "R8");
        step(0, '0, 1, 0, 1, "R8");
        step(0, '0, 1, 1, 1, "R8");
        step(0, '0, 1, 0, 1, "R4");
        // R5: branch with a response in the same cycle
        step(1, 32'h0000_0200, 1, 0, 1, "R5");
        step(0, '0, 1, 0, 1, "R5");
        // R5/R6: unaligned branch with no response, then stale data discarded
        step(1, 32'h0000_0303, 1, 0, 0, "R5");
        step(0, '0, 1, 0, 1, "R6");
        step(0, '0, 1, 0, 1, "R6");
        // R6: second branch while draining, error ends the drain
        step(1, 32'h0000_0400, 1, 0, 0, "R5");
        step(1, 32'h0000_0500, 1, 0, 0, "R6");
        step(0, '0, 1, 0, 0, "R6");
        step(0, '0, 1, 1, 0, "R6");
        step(0, '0, 1, 0, 1, "R6");
        // R5: branch beats stall
        step(1, 32'h0000_0600, 0, 0, 0, "R5");
        step(0, '0, 0, 0, 1, "R7");
        step(0, '0, 1, 0, 1, "R5");
        // R4: counter wrap
        step(1, 32'hFFFF_FFFC, 1, 0, 1, "R5");
        step(0, '0, 1, 0, 1, "R4");
        step(0, '0, 1, 0, 1, "R4");
        step(0, '0, 1, 0, 0, "R4");
        step(0, '0, 1, 0, 0, "R4");

        @(negedge clk);
        look(pend);
        @(negedge clk);
        chk(exp_q.size() == 0, "R4", "scoreboard drained", 64'(exp_q.size()), 64'd0);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule